// File: doc/BRIEF.md
# Configurable Loop Accumulator Core

This block is a small specialised coprocessor that executes a single counted loop whose body is chosen by control bits. A host shifts a configuration word into the core over a serial scan chain: an ALU opcode, an operand select, a trip count and a starting value. It then pulses `start`. The core clears its loop counter, seeds its accumulator with the starting value and performs one loop iteration per clock cycle until the counter reaches the trip count.

In each iteration the ALU combines the accumulator with a second operand. That operand is either the accumulator itself or the current loop index. Changing only the select and opcode makes the same datapath compute different things. With a zero seed, the index operand and addition, it produces an index sum. With the accumulator operand and multiplication, it squares the value on every pass. With the accumulator operand and addition, it doubles the value on every pass.

When `done` is set, the host reads the result back through the same scan chain, most significant bit first. The copy of the loop index used as an operand is kept still while the accumulator is the selected operand, so that unused path does not toggle.

Top module: `loop_accel_core`

## Requirements
- R1: A `start` pulse accepted while idle clears the loop counter and loads the accumulator with the configured seed. If the trip count is 0, `done` rises in the same edge, `busy` stays low, and the result equals the seed.
- R2: With a trip count n>0, the loop runs exactly n iterations, one per clock. `busy` is high for exactly n cycles after the edge that accepts `start`, and the counter steps by one on each iteration.
- R3: The select bit picks the second ALU operand: 1 selects the loop index (0 to n-1 across the iterations), 0 selects the current accumulator.
- R4: Opcode 2'b00 adds and opcode 2'b01 multiplies. Both keep only the low 32 bits of the result, so arithmetic wraps.
- R5: Opcodes 2'b10 and 2'b11 are pass-through: the accumulator takes the selected operand unchanged.
- R6: While `scan_en` is high and the core is idle, the 67-bit configuration chain shifts in `scan_in` once per clock. Bits are loaded MSB first in the order opcode (2 bits), select (1 bit), trip count (32 bits), seed (32 bits).
- R7: `scan_out` always shows the accumulator MSB. Each idle clock with `scan_en` high shifts the accumulator left by one and fills in a zero, so 32 shifts read out the result MSB first and leave the accumulator at zero.
- R8: `done` is low while `busy` is high. Once set, it stays set until the next accepted `start`.
- R9: While `busy` is high, `start` and `scan_en` have no effect: the configuration, the iteration count and the result are unchanged.
- R10: The loop-index operand register holds its value during every iteration in which the accumulator is the selected operand.
- R11: After reset, `busy` and `done` are low and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | Shift enable for the configuration and result chains |
| scan_in | input | 1 | Serial configuration data, MSB first |
| scan_out | output | 1 | Serial result data (accumulator MSB) |
| start | input | 1 | Pulse to launch the loop when idle |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | Sticky completion flag |

## Verification
The hardest case to reach from the ports is host activity arriving in the middle of a run. This means a second `start` pulse and scan shifting during the cycles when iterations are executing. The stimulus reaches it by launching a six-iteration index sum and then, while counting `busy` cycles at the falling edge, driving a `start` pulse and several cycles of toggling scan data before the run ends. It then checks that the iteration count and the result are unchanged. Without rescanning, it launches again to show that the stored configuration also survived. The zero trip count is the other edge case: there, `done` must appear with no `busy` cycle at all.

// File: rtl/loopacc_pkg.sv
// Shared definitions for the loop accumulator core.
// Assumes a 2-bit opcode field; codes above MUL act as pass-through.
package loopacc_pkg;

    localparam int OPW = 2;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 2'b00,
        OP_MUL   = 2'b01,
        OP_PASSA = 2'b10,
        OP_PASSB = 2'b11
    } alu_op_e;

endpackage

// File: rtl/loopacc_scan.sv
// Configuration scan chain: a shift register that takes scan_in at the LSB
// each enabled cycle. Fields are decoded from fixed slices.
// Assumes the parent gates shift_en off while the loop is running.
module loopacc_scan #(
    parameter int DW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic                      scan_in,
    output loopacc_pkg::alu_op_e      cfg_op,
    output logic                      cfg_sel,
    output logic [DW-1:0]             cfg_n,
    output logic [DW-1:0]             cfg_b,
    output logic [loopacc_pkg::OPW+2*DW:0] cfg_word
);
    import loopacc_pkg::*;

    localparam int CW = OPW + 1 + 2*DW;

    logic [CW-1:0] chain_q;

    // Shift the configuration chain one bit toward the MSB when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {chain_q[CW-2:0], scan_in};
        end
    end

    assign cfg_op   = alu_op_e'(chain_q[CW-1 -: OPW]);
    assign cfg_sel  = chain_q[2*DW];
    assign cfg_n    = chain_q[2*DW-1 -: DW];
    assign cfg_b    = chain_q[DW-1:0];
    assign cfg_word = chain_q;

endmodule

// File: rtl/loopacc_ctrl.sv
// Loop control: accepts start when idle, keeps the iteration counter and
// produces busy and the sticky done flag.
// Assumes cfg_n is stable while busy (the scan chain is frozen then).
module loopacc_ctrl #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] cfg_n,
    output logic          launch,
    output logic          step,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cnt_next
);

    logic last_iter;

    // Decode launch, iteration and final-iteration conditions.
    always_comb begin
        launch    = start && !busy;
        step      = busy;
        cnt_next  = cnt + 1'b1;
        last_iter = (cnt_next == cfg_n);
    end

    // Counter and busy/done sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (launch) begin
            cnt  <= '0;
            busy <= (cfg_n != '0);
            done <= (cfg_n == '0);
        end else if (step) begin
            cnt <= cnt_next;
            if (last_iter) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/loopacc_datapath.sv
// Datapath: operand multiplexer, ALU and accumulator with serial readout.
// The index operand register follows the counter only while it is the
// selected operand and holds otherwise, so that path stays quiet.
// Assumes launch and step are mutually exclusive with readout shifting.
module loopacc_datapath #(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 step,
    input  logic                 read_shift,
    input  loopacc_pkg::alu_op_e op,
    input  logic                 sel_idx,
    input  logic [DW-1:0]        seed,
    input  logic [DW-1:0]        cnt_next,
    output logic [DW-1:0]        acc,
    output logic [DW-1:0]        idx_q
);
    import loopacc_pkg::*;

    logic [DW-1:0] opnd;
    logic [DW-1:0] alu_y;

    // Operand mux and ALU for one iteration.
    always_comb begin
        opnd = sel_idx ? idx_q : acc;
        case (op)
            OP_ADD:  alu_y = acc + opnd;
            OP_MUL:  alu_y = acc * opnd;
            default: alu_y = opnd;
        endcase
    end

    // Accumulator: seed on launch, update per iteration, shift on readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (launch) begin
            acc <= seed;
        end else if (step) begin
            acc <= alu_y;
        end else if (read_shift) begin
            acc <= {acc[DW-2:0], 1'b0};
        end
    end

    // Index operand register: tracks the counter only when selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (sel_idx && launch) begin
            idx_q <= '0;
        end else if (sel_idx && step) begin
            idx_q <= cnt_next;
        end
    end

endmodule

// File: rtl/loop_accel_core.sv
// Top of the configurable loop accumulator core. Scan chain in, one loop
// iteration per clock, result read out through scan_out.
// Assumes the host only shifts or starts while busy is low.
module loop_accel_core (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic scan_in,
    output logic scan_out,
    input  logic start,
    output logic busy,
    output logic done
);
    import loopacc_pkg::*;

    localparam int DW = 32;
    localparam int CW = OPW + 1 + 2*DW;

    alu_op_e       cfg_op;
    logic          cfg_sel;
    logic [DW-1:0] cfg_n;
    logic [DW-1:0] cfg_b;
    logic [CW-1:0] cfg_word;
    logic          launch;
    logic          step;
    logic [DW-1:0] cnt;
    logic [DW-1:0] cnt_next;
    logic [DW-1:0] acc;
    logic [DW-1:0] idx_q;
    logic          idle_shift;

    // Scan shifting is accepted only while no loop is running.
    assign idle_shift = scan_en && !busy;
    assign scan_out   = acc[DW-1];

    loopacc_scan #(.DW(DW)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (idle_shift),
        .scan_in  (scan_in),
        .cfg_op   (cfg_op),
        .cfg_sel  (cfg_sel),
        .cfg_n    (cfg_n),
        .cfg_b    (cfg_b),
        .cfg_word (cfg_word)
    );

    loopacc_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_n    (cfg_n),
        .launch   (launch),
        .step     (step),
        .busy     (busy),
        .done     (done),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    loopacc_datapath #(.DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .step       (step),
        .read_shift (idle_shift),
        .op         (cfg_op),
        .sel_idx    (cfg_sel),
        .seed       (cfg_b),
        .cnt_next   (cnt_next),
        .acc        (acc),
        .idx_q      (idx_q)
    );

endmodule

// File: rtl/loop_accel_core_checker.sv
// Property checker for loop_accel_core, attached with bind below.
// Observes ports plus configuration, counter and datapath registers.
module loop_accel_core_checker #(
    parameter int DW = 32,
    parameter int CW = 67
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          cfg_sel,
    input logic [DW-1:0] cfg_b,
    input logic [CW-1:0] cfg_word,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] idx_q
);

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8

    AST_LAUNCH_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (acc == $past(cfg_b) && cnt == '0)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_word)); // R9

    AST_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_sel) |=> $stable(idx_q)); // R10

endmodule

bind loop_accel_core loop_accel_core_checker #(.DW(32), .CW(67)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .cfg_sel  (cfg_sel),
    .cfg_b    (cfg_b),
    .cfg_word (cfg_word),
    .cnt      (cnt),
    .acc      (acc),
    .idx_q    (idx_q)
);

// File: tb/loop_accel_core_test.sv
// Directed bench for loop_accel_core: one task per scenario, each checking
// its own results. Inputs change and outputs are sampled on falling edges.
module loop_accel_core_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b0;
    logic scan_in = 1'b0;
    logic start = 1'b0;
    logic scan_out;
    logic busy;
    logic done;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    loop_accel_core uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .scan_out (scan_out),
        .start    (start),
        .busy     (busy),
        .done     (done)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    // Shift a configuration word in, MSB first: opcode, select, n, b.
    task automatic scan_load(input logic [1:0] op, input logic sel,
                             input logic [31:0] n, input logic [31:0] b);
        logic [66:0] w;
        w = {op, sel, n, b};
        for (int i = 66; i >= 0; i--) begin
            scan_en = 1'b1;
            scan_in = w[i];
            @(negedge clk);
        end
        scan_en = 1'b0;
        scan_in = 1'b0;
    endtask

    // Pulse start, then count falling edges on which busy is high.
    task automatic launch_run(output int bcount);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bcount = 0;
        while (busy) begin
            bcount++;
            @(negedge clk);
        end
    endtask

    // Read the 32-bit accumulator MSB first through scan_out.
    task automatic read_acc(output logic [31:0] r);
        r = '0;
        for (int i = 0; i < 32; i++) begin
            r = {r[30:0], scan_out};
            scan_en = 1'b1;
            @(negedge clk);
        end
        scan_en = 1'b0;
    endtask

    task automatic run_case(input string req, input logic [1:0] op, input logic sel,
                            input logic [31:0] n, input logic [31:0] b,
                            input logic [31:0] exp);
        int bc;
        logic [31:0] r;
        scan_load(op, sel, n, b);
        launch_run(bc);
        chk({req, " busy cycles"}, bc, n);
        chk({req, " done"}, {31'b0, done}, 32'd1);
        read_acc(r);
        chk({req, " result"}, r, exp);
    endtask

    task automatic t_reset;
        chk("R11 busy", {31'b0, busy}, 0);
        chk("R11 done", {31'b0, done}, 0);
        chk("R11 acc msb", {31'b0, scan_out}, 0);
    endtask

    task automatic t_index_sum;   // R3 index operand, R4 add, R2 count, R6 load
        run_case("R3/R4 sum", 2'b00, 1'b1, 32'd5, 32'd0, 32'd10);
        run_case("R2 sum100", 2'b00, 1'b1, 32'd100, 32'd0, 32'd4950);
    endtask

    task automatic t_square;      // R3 accumulator operand, R4 multiply
        run_case("R4 square", 2'b01, 1'b0, 32'd3, 32'd3, 32'd6561);
        run_case("R3 double", 2'b00, 1'b0, 32'd3, 32'd1, 32'd8);
    endtask

    task automatic t_wrap;        // R4 wraparound
        run_case("R4 mulwrap", 2'b01, 1'b0, 32'd1, 32'h0001_0000, 32'd0);
        run_case("R4 addwrap", 2'b00, 1'b0, 32'd1, 32'h8000_0001, 32'd2);
    endtask

    task automatic t_zero_trip;   // R1
        logic [31:0] r;
        int bc;
        scan_load(2'b01, 1'b0, 32'd0, 32'hDEAD_BEEF);
        launch_run(bc);
        chk("R1 zero trip busy", bc, 0);
        chk("R1 zero trip done", {31'b0, done}, 1);
        read_acc(r);
        chk("R1 zero trip result", r, 32'hDEAD_BEEF);
    endtask

    task automatic t_pass;        // R5
        run_case("R5 pass idx", 2'b10, 1'b1, 32'd4, 32'd7, 32'd3);
        run_case("R5 pass acc", 2'b11, 1'b0, 32'd4, 32'h1234, 32'h1234);
    endtask

    task automatic t_readout;     // R7
        logic [31:0] r;
        run_case("R7 readout", 2'b00, 1'b1, 32'd3, 32'hF000_0000, 32'hF000_0003);
        chk("R7 acc emptied", {31'b0, scan_out}, 0);
        read_acc(r);
        chk("R7 zeros after read", r, 0);
    endtask

    task automatic t_busy_ignore; // R9
        int bc;
        logic [31:0] r;
        scan_load(2'b00, 1'b1, 32'd6, 32'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bc = 0;
        while (busy) begin
            bc++;
            if (bc == 2) start = 1'b1;
            else start = 1'b0;
            scan_en = (bc >= 2 && bc <= 4);
            scan_in = bc[0];
            @(negedge clk);
        end
        start = 1'b0;
        scan_en = 1'b0;
        scan_in = 1'b0;
        chk("R9 busy cycles", bc, 6);
        // Relaunch without rescanning: the configuration must be intact.
        launch_run(bc);
        chk("R9 relaunch cycles", bc, 6);
        read_acc(r);
        chk("R9 result", r, 32'd15);
    endtask

    task automatic t_done_sticky; // R8
        int bc;
        scan_load(2'b00, 1'b1, 32'd4, 32'd0);
        launch_run(bc);
        repeat (5) @(negedge clk);
        chk("R8 done held", {31'b0, done}, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 done cleared", {31'b0, done}, 0);
        chk("R8 busy on run", {31'b0, busy}, 1);
        while (busy) @(negedge clk);
        chk("R8 done again", {31'b0, done}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index_sum();
        t_square();
        t_wrap();
        t_zero_trip();
        t_pass();
        t_readout();
        t_busy_ignore();
        t_done_sticky();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule